// File: doc/BRIEF.md
# Bus-Mapped RAM, Dual Port and Edge-Interrupt Peripheral

This block sits on a simple synchronous processor bus and offers three resources behind one address decode: a 128-byte scratch memory, two 8-bit general-purpose ports with a per-pin direction control, and an interrupt source that watches the top pin of port A for a chosen edge. Every bus signal is sampled on the rising clock edge. A read result is registered and appears on `rdata` during the cycle after the access edge.

The interrupt flag register also carries a flag from an external interval timer. The timer's own counting logic lives elsewhere and hands in its pending flag and its enable. Edge polarity and the port-A interrupt enable are set by the address lines of a read access into the control space, not by written data. An active-low interrupt request is pulled low while an enabled source is pending.

Top module: `rp_periph`

## Requirements
- R1: The block acts on an access only when `cs_hi` is 1 and `cs_lo_n` is 0. Otherwise no register or memory changes and `rdata` is 0 in the next cycle.
- R2: With `ram_sel_n` = 0, a write stores `wdata` at `addr[6:0]`, and a read returns that byte on `rdata` in the cycle after the access edge.
- R3: With `ram_sel_n` = 1 and `addr[2]` = 0, `addr[1:0]` selects a port register: 00 is port A output, 01 is port A direction, 10 is port B output, 11 is port B direction. Writes load `wdata` into the selected register.
- R4: Each port drives its output register on `p*_out` and its direction register on `p*_oe` (1 means output). A read of an output register returns the pin level on input bits and the register bit on output bits. A read of a direction register returns the register.
- R5: A read with `ram_sel_n` = 1, `addr[2]` = 1 and `addr[4]` = 0 sets the port-A interrupt enable to the inverse of `addr[1]` and sets the polarity to rising if `addr[0]` = 1, falling if 0. Writes to the control space change neither.
- R6: A read with `ram_sel_n` = 1, `addr[2]` = 1 and `addr[0]` = 1 returns the flag register: bit 7 is the timer flag, bit 6 is the edge flag, and bits 5..0 are 0. The edge flag is cleared after that read, except when a new qualifying edge arrives in the same cycle, in which case it stays set.
- R7: The edge flag sets when `pa_in[7]` differs from its value at the previous clock in the direction the polarity selects. It sets whether or not the interrupt is enabled.
- R8: `irq_n` is 0 exactly while (edge flag and its enable) or (`tmr_flag` and `tmr_en`) holds, and is 1 otherwise.
- R9: A low `rst_n` clears both output and both direction registers, the edge flag and its enable, selects falling polarity, and sets `rdata` to 0, which leaves `irq_n` high.
- R10: `rd_wr` = 1 is a read and 0 is a write. `rdata` is 0 in the cycle after any write access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_hi | input | 1 | Active-high chip select |
| cs_lo_n | input | 1 | Active-low chip select |
| ram_sel_n | input | 1 | 0 selects the memory, 1 the register space |
| rd_wr | input | 1 | 1 read, 0 write |
| addr | input | 7 | Access address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output register |
| pa_oe | output | 8 | Port A direction, 1 = drive |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output register |
| pb_oe | output | 8 | Port B direction, 1 = drive |
| tmr_flag | input | 1 | Pending flag from the interval timer |
| tmr_en | input | 1 | Timer interrupt enable |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The hardest case is a qualifying edge on the top port-A pin in the same clock as the flag read that would clear the flag. The edge must win, while the read still returns the old flag value. To reach it, the stimulus toggles `pa_in[7]` on the same falling clock edge that presents the flag read, so both land on one rising edge. The bench then checks both the returned byte and that the request stays low. A second subtle path is a write into the control space that must not reprogram the enable. The stimulus issues such a write and then shows, through a later edge, that the request still asserts.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int unsigned RP_DW = 8;
  localparam int unsigned RP_AW = 7;
  localparam int unsigned RP_NPORT = 2;
  localparam int unsigned RP_TMR_BIT = 7;
  localparam int unsigned RP_EDGE_BIT = 6;

  typedef enum logic {
    POL_FALL = 1'b0,
    POL_RISE = 1'b1
  } edge_pol_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ram;
    logic port;
    logic ctl;
  } acc_t;
endpackage

// File: rtl/rp_ram.sv
module rp_ram #(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata_c
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[addr] <= wdata;
    end
  end

  assign rdata_c = mem_q[addr];
endmodule

// File: rtl/rp_port.sv
module rp_port #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_out,
  input  logic          wr_dir,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] pin_in,
  output logic [DW-1:0] drv,
  output logic [DW-1:0] oe,
  output logic [DW-1:0] rd_mix,
  output logic [DW-1:0] rd_dir
);
  logic [DW-1:0] out_q, out_d;
  logic [DW-1:0] dir_q, dir_d;

  always_comb begin
    out_d = out_q;
    dir_d = dir_q;
    if (wr_out) out_d = wdata;
    if (wr_dir) dir_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      dir_q <= '0;
    end else begin
      out_q <= out_d;
      dir_q <= dir_d;
    end
  end

  assign drv    = out_q;
  assign oe     = dir_q;
  assign rd_mix = (pin_in & ~dir_q) | (out_q & dir_q);
  assign rd_dir = dir_q;

  // R3: without a direction write strobe the direction register holds
  p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(dir_q));
  // R3: without an output write strobe the output register holds
  p_out_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_out |=> $stable(out_q));
endmodule

// File: rtl/rp_edge_irq.sv
module rp_edge_irq
  import rp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pa7,
  input  logic ctl_rd,
  input  logic ctl_a1,
  input  logic ctl_a0,
  input  logic flag_rd,
  input  logic tmr_flag,
  input  logic tmr_en,
  output logic edge_flag,
  output logic irq_n
);
  logic      en_q, en_d;
  edge_pol_e pol_q, pol_d;
  logic      prev_q;
  logic      flag_q, flag_d;
  logic      edge_hit;

  always_comb begin
    edge_hit = (pol_q == POL_RISE) ? (~prev_q & pa7) : (prev_q & ~pa7);
    en_d  = en_q;
    pol_d = pol_q;
    if (ctl_rd) begin
      en_d  = ~ctl_a1;
      pol_d = ctl_a0 ? POL_RISE : POL_FALL;
    end
    flag_d = flag_q;
    if (edge_hit)     flag_d = 1'b1;
    else if (flag_rd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pol_q  <= POL_FALL;
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      pol_q  <= pol_d;
      prev_q <= pa7;
      flag_q <= flag_d;
    end
  end

  assign edge_flag = flag_q;
  assign irq_n = ~((flag_q & en_q) | (tmr_flag & tmr_en));

  // R6: a flag read with no coinciding edge leaves the flag clear
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_rd && !edge_hit) |=> !flag_q);
  // R7: the flag only rises after the pin changed between two samples
  p_flag_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> ($past(pa7) != $past(prev_q)));
  // R5: a control read programs enable and polarity from its address bits
  p_ctl_prog_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_rd |=> (en_q == !$past(ctl_a1)) && ((pol_q == POL_RISE) == $past(ctl_a0)));
endmodule

// File: rtl/rp_periph.sv
module rp_periph
  import rp_pkg::*;
#(
  parameter int unsigned AW = RP_AW,
  parameter int unsigned DW = RP_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_hi,
  input  logic          cs_lo_n,
  input  logic          ram_sel_n,
  input  logic          rd_wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [DW-1:0] pa_in,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pa_oe,
  input  logic [DW-1:0] pb_in,
  output logic [DW-1:0] pb_out,
  output logic [DW-1:0] pb_oe,
  input  logic          tmr_flag,
  input  logic          tmr_en,
  output logic          irq_n
);
  localparam int unsigned NPORT = RP_NPORT;

  acc_t          acc;
  logic          sel;
  logic [DW-1:0] ram_rd;
  logic [DW-1:0] pin_in_a [NPORT];
  logic [DW-1:0] drv_a    [NPORT];
  logic [DW-1:0] oe_a     [NPORT];
  logic [DW-1:0] mix_a    [NPORT];
  logic [DW-1:0] dir_a    [NPORT];
  logic          edge_flag;
  logic          ctl_rd;
  logic          flag_rd;
  logic [DW-1:0] rdata_q, rdata_d;

  // access decode
  always_comb begin
    sel      = cs_hi & ~cs_lo_n;
    acc.rd   = sel & rd_wr;
    acc.wr   = sel & ~rd_wr;
    acc.ram  = ~ram_sel_n;
    acc.port = ram_sel_n & ~addr[2];
    acc.ctl  = ram_sel_n & addr[2];
  end

  assign ctl_rd  = acc.rd & acc.ctl & ~addr[4];
  assign flag_rd = acc.rd & acc.ctl & addr[0];

  rp_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk     (clk),
    .we      (acc.wr & acc.ram),
    .addr    (addr),
    .wdata   (wdata),
    .rdata_c (ram_rd)
  );

  assign pin_in_a[0] = pa_in;
  assign pin_in_a[1] = pb_in;

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
    rp_port #(.DW(DW)) u_port (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_out (acc.wr & acc.port & (addr[1] == gi[0]) & ~addr[0]),
      .wr_dir (acc.wr & acc.port & (addr[1] == gi[0]) &  addr[0]),
      .wdata  (wdata),
      .pin_in (pin_in_a[gi]),
      .drv    (drv_a[gi]),
      .oe     (oe_a[gi]),
      .rd_mix (mix_a[gi]),
      .rd_dir (dir_a[gi])
    );
  end

  assign pa_out = drv_a[0];
  assign pa_oe  = oe_a[0];
  assign pb_out = drv_a[1];
  assign pb_oe  = oe_a[1];

  rp_edge_irq u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .pa7       (pa_in[DW-1]),
    .ctl_rd    (ctl_rd),
    .ctl_a1    (addr[1]),
    .ctl_a0    (addr[0]),
    .flag_rd   (flag_rd),
    .tmr_flag  (tmr_flag),
    .tmr_en    (tmr_en),
    .edge_flag (edge_flag),
    .irq_n     (irq_n)
  );

  // read data next state
  always_comb begin
    rdata_d = '0;
    if (acc.rd) begin
      if (acc.ram) begin
        rdata_d = ram_rd;
      end else if (acc.port) begin
        rdata_d = addr[0] ? dir_a[addr[1]] : mix_a[addr[1]];
      end else if (addr[0]) begin
        rdata_d[RP_TMR_BIT]  = tmr_flag;
        rdata_d[RP_EDGE_BIT] = edge_flag;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

  // R1, R10: no read access means zero on the data bus next cycle
  p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_hi && !cs_lo_n && rd_wr) |=> (rdata == '0));
  // R1: a deselected cycle changes no port pin register
  p_desel_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_hi && !cs_lo_n) |=> $stable(pa_oe) && $stable(pb_out));
endmodule

// File: tb/tb_rp_periph.sv
`timescale 1ns/1ps
module tb_rp_periph;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_hi, cs_lo_n, ram_sel_n, rd_wr;
  logic [6:0] addr;
  logic [7:0] wdata, rdata;
  logic [7:0] pa_in, pa_out, pa_oe, pb_in, pb_out, pb_oe;
  logic       tmr_flag, tmr_en, irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rp_periph dut (
    .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
    .ram_sel_n(ram_sel_n), .rd_wr(rd_wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .tmr_flag(tmr_flag), .tmr_en(tmr_en), .irq_n(irq_n)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    cs_hi = 1'b0; cs_lo_n = 1'b1; rd_wr = 1'b1; ram_sel_n = 1'b1;
    addr = '0; wdata = '0;
  endtask

  task automatic access(input logic rw, input logic rs_n, input logic [6:0] a,
                        input logic [7:0] d, input logic c1, input logic c2n,
                        output logic [7:0] q);
    @(negedge clk);
    cs_hi = c1; cs_lo_n = c2n; rd_wr = rw; ram_sel_n = rs_n; addr = a; wdata = d;
    @(negedge clk);
    q = rdata;
    idle();
  endtask

  task automatic wr(input logic rs_n, input logic [6:0] a, input logic [7:0] d);
    logic [7:0] q;
    access(1'b0, rs_n, a, d, 1'b1, 1'b0, q);
    check(q == 8'h00, "R10 write returns zero", q, 0);
  endtask

  task automatic rd(input logic rs_n, input logic [6:0] a, output logic [7:0] q);
    access(1'b1, rs_n, a, 8'h00, 1'b1, 1'b0, q);
  endtask

  task automatic set_pa7(input logic v);
    @(negedge clk);
    pa_in[7] = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] q;
    check(rdata == 8'h00, "R9 rdata after reset", rdata, 0);
    check(irq_n == 1'b1, "R9 irq_n after reset", irq_n, 1);
    check(pa_oe == 8'h00 && pb_oe == 8'h00, "R9 direction cleared", {pa_oe, pb_oe}, 0);
    check(pa_out == 8'h00 && pb_out == 8'h00, "R9 output cleared", {pa_out, pb_out}, 0);
    rd(1'b1, 7'h15, q);
    check(q == 8'h00, "R9 flags cleared", q, 0);
  endtask

  task automatic t_ram();
    logic [7:0] q;
    wr(1'b0, 7'h00, 8'h11);
    wr(1'b0, 7'h7F, 8'hEE);
    wr(1'b0, 7'h55, 8'h5A);
    rd(1'b0, 7'h00, q); check(q == 8'h11, "R2 ram low", q, 8'h11);
    rd(1'b0, 7'h7F, q); check(q == 8'hEE, "R2 ram high", q, 8'hEE);
    rd(1'b0, 7'h55, q); check(q == 8'h5A, "R2 ram mid", q, 8'h5A);
    check(pa_oe == 8'h00, "R2 ram write leaves ports", pa_oe, 0);
  endtask

  task automatic t_ports();
    logic [7:0] q;
    wr(1'b1, 7'h01, 8'h0F);
    wr(1'b1, 7'h00, 8'hA5);
    wr(1'b1, 7'h03, 8'hF0);
    wr(1'b1, 7'h02, 8'h3C);
    check(pa_out == 8'hA5 && pa_oe == 8'h0F, "R3 port A regs", {pa_out, pa_oe}, 16'hA50F);
    check(pb_out == 8'h3C && pb_oe == 8'hF0, "R3 port B regs", {pb_out, pb_oe}, 16'h3CF0);
    pa_in = 8'h3C; pb_in = 8'hC3;
    rd(1'b1, 7'h00, q); check(q == 8'h35, "R4 port A mix", q, 8'h35);
    rd(1'b1, 7'h02, q); check(q == 8'h33, "R4 port B mix", q, 8'h33);
    rd(1'b1, 7'h01, q); check(q == 8'h0F, "R4 direction A read", q, 8'h0F);
    rd(1'b1, 7'h03, q); check(q == 8'hF0, "R4 direction B read", q, 8'hF0);
    pa_in = 8'h00;
  endtask

  task automatic t_deselect();
    logic [7:0] q;
    access(1'b0, 1'b1, 7'h01, 8'hFF, 1'b0, 1'b0, q);
    access(1'b0, 1'b1, 7'h01, 8'hFF, 1'b1, 1'b1, q);
    check(pa_oe == 8'h0F, "R1 deselected write ignored", pa_oe, 8'h0F);
    access(1'b1, 1'b1, 7'h01, 8'h00, 1'b1, 1'b1, q);
    check(q == 8'h00, "R1 deselected read zero", q, 0);
    rd(1'b1, 7'h01, q);
    check(q == 8'h0F, "R1 register intact", q, 8'h0F);
  endtask

  task automatic t_edge();
    logic [7:0] q;
    rd(1'b1, 7'h05, q);
    set_pa7(1'b1);
    check(irq_n == 1'b0, "R7 rising edge asserts", irq_n, 0);
    rd(1'b1, 7'h15, q);
    check(q == 8'h40, "R6 flag read value", q, 8'h40);
    check(irq_n == 1'b1, "R6 flag cleared after read", irq_n, 1);
    rd(1'b1, 7'h15, q);
    check(q == 8'h00, "R6 flag stays clear", q, 0);
    set_pa7(1'b0);
    check(irq_n == 1'b1, "R7 wrong direction ignored", irq_n, 1);
    rd(1'b1, 7'h04, q);
    set_pa7(1'b1);
    check(irq_n == 1'b1, "R7 rising ignored when falling", irq_n, 1);
    set_pa7(1'b0);
    check(irq_n == 1'b0, "R7 falling edge asserts", irq_n, 0);
    rd(1'b1, 7'h06, q);
    check(irq_n == 1'b1, "R8 disabled source masked", irq_n, 1);
    rd(1'b1, 7'h15, q);
    check(q == 8'h40, "R7 flag set while disabled", q, 8'h40);
  endtask

  task automatic t_ctl_write();
    logic [7:0] q;
    rd(1'b1, 7'h04, q);
    pa_in[7] = 1'b1;
    wr(1'b1, 7'h06, 8'hFF);
    wr(1'b1, 7'h07, 8'h00);
    set_pa7(1'b0);
    check(irq_n == 1'b0, "R5 control write ignored", irq_n, 0);
    rd(1'b1, 7'h15, q);
    check(irq_n == 1'b1, "R6 clear before collision", irq_n, 1);
  endtask

  task automatic t_collision();
    @(negedge clk);
    pa_in[7] = 1'b1;
    @(negedge clk);
    pa_in[7] = 1'b0;
    cs_hi = 1'b1; cs_lo_n = 1'b0; rd_wr = 1'b1; ram_sel_n = 1'b1; addr = 7'h15;
    @(negedge clk);
    check(rdata == 8'h00, "R6 collision returns old flag", rdata, 0);
    check(irq_n == 1'b0, "R6 collision edge kept", irq_n, 0);
    idle();
    @(negedge clk);
    check(irq_n == 1'b0, "R6 collision flag persists", irq_n, 0);
  endtask

  task automatic t_timer();
    logic [7:0] q;
    rd(1'b1, 7'h15, q);
    tmr_flag = 1'b1; tmr_en = 1'b0;
    #1;
    check(irq_n == 1'b1, "R8 timer masked", irq_n, 1);
    tmr_en = 1'b1;
    #1;
    check(irq_n == 1'b0, "R8 timer request", irq_n, 0);
    rd(1'b1, 7'h15, q);
    check(q == 8'h80, "R6 timer flag bit", q, 8'h80);
    tmr_flag = 1'b0; tmr_en = 1'b0;
    #1;
    check(irq_n == 1'b1, "R8 released", irq_n, 1);
  endtask

  task automatic t_rereset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check(pa_oe == 8'h00 && pb_out == 8'h00, "R9 reset mid run", {pa_oe, pb_out}, 0);
  endtask

  initial begin
    idle();
    pa_in = '0; pb_in = '0; tmr_flag = 1'b0; tmr_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ram();
    t_ports();
    t_deselect();
    t_edge();
    t_ctl_write();
    t_collision();
    t_timer();
    t_rereset();
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule